// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a free-running time of day for a precision time protocol endpoint. Time is held as a 32-bit seconds count and a 30-bit nanoseconds count. Every clock cycle the nanoseconds advance by a nominal 4 ns. A 32-bit fractional accumulator, driven by a signed rate trim, adds or removes one extra nanosecond now and then, so the clock's rate can be tuned in parts per million. One ppm corresponds to 17179 trim units, where one unit is 2^-32 ns per cycle.

A host reaches the counter through a small synchronous register port: 16-bit writes to staging registers, a combinational 16-bit read mux, and a one-cycle command strobe with an operation code. There are five operations. A load copies the staged absolute time into the counter. A snapshot freezes the current time into read registers, so the halves can be read without tearing. A rate command activates the staged trim. A seconds step moves the seconds by a bounded signed amount. A nanoseconds step adds a staged offset, and any carry passes into the seconds.

Register addresses: 0 seconds-set high, 1 seconds-set low, 2 nanoseconds-set high (14 bits), 3 nanoseconds-set low, 4 rate high (bit 15 = faster, bits 13:0 = magnitude 29:16), 5 rate low, 6 step high (bit 15 = add, bits 13:0 = magnitude 29:16), 7 step low, 8 to 11 snapshot seconds high/low and nanoseconds high/low. Any other read address returns zero. Operation codes: 1 load, 2 snapshot, 3 rate, 4 seconds step, 5 nanoseconds step. All other codes do nothing.

Top module: `ptp_time_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the time, the fractional accumulator, the active trim, every staging register and the snapshot registers are cleared. Right after reset, `tod_sec`, `tod_ns` and every readable address return zero.
- R2: With a zero active trim and no command, `tod_ns` grows by exactly 4 on each rising edge.
- R3: When the nanoseconds reach or pass 1,000,000,000, that amount is taken off and the seconds count up by one. For example, 999,999,996 followed by one tick gives seconds+1 and 0 ns.
- R4: Code 1 (load) makes `tod_sec` and `tod_ns` equal the staged set values on the edge that sees the strobe. The upper nanoseconds set half keeps only bits 13:0, so writing 0xFFFF to address 2 reads back 0x3FFF.
- R5: Code 2 (snapshot) captures the time present at the strobe edge into addresses 8 to 11. These values hold unchanged until the next snapshot, however far the clock runs on.
- R6: After code 3 (rate), the staged 30-bit magnitude is added to the accumulator each cycle when bit 15 of address 4 is set, or subtracted when it is clear. Each overflow adds 1 ns and each underflow removes 1 ns. A magnitude of 0x1000_0000 over 160 cycles gives +10 ns or -10 ns against nominal.
- R7: Code 4 (seconds step) adds the staged magnitude to the seconds when bit 15 of address 6 is set, and subtracts it when clear. The magnitude is clamped to 15. The normal nanosecond tick still happens in that cycle.
- R8: Code 5 (nanoseconds step) adds the staged 30-bit magnitude to the nanoseconds in the same cycle as the normal tick, ignoring the direction bit. A result of one or two billion or more carries one or two seconds.
- R9: Codes 0, 6 and 7, and any code presented while `cmd_strobe` is low, leave the time running at the nominal rate with no other effect.
- R10: Writing the rate registers alone does not change the counting rate until code 3 is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock (4 ns nominal per cycle) |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write enable for staging registers |
| reg_wr_addr | input | 4 | Write address |
| reg_wr_data | input | 16 | Write data |
| reg_rd_addr | input | 4 | Read address |
| reg_rd_data | output | 16 | Combinational read data |
| cmd_strobe | input | 1 | One-cycle command strobe |
| cmd_code | input | 3 | Operation code sampled with the strobe |
| tod_sec | output | 32 | Live seconds |
| tod_ns | output | 30 | Live nanoseconds |

## Verification
The assertions assume the host never loads a nanoseconds value of one billion or more. They also assume exactly one operation is carried per strobe, so the nanoseconds stay below one billion and a seconds step moves the count by at most sixteen. The stimulus only loads legal nanosecond values, including ones just below the wrap point. It issues steps and loads one strobe at a time, checking each outcome at the falling edge after the command edge. Rate tests start from a reset accumulator, so the number of extra or missing nanoseconds over a fixed window can be predicted exactly.

// File: rtl/ptc_pkg.sv
// Shared constants, register addresses and operation codes for the
// time-of-day counter. Assumes 16-bit register halves.
package ptc_pkg;
    localparam int SEC_W        = 32;
    localparam int NS_W         = 30;
    localparam int HALF_W       = 16;
    localparam int ADDR_W       = 4;
    localparam int FRAC_W       = 32;
    localparam int INC_W        = 3;
    localparam int NOM_INC      = 4;
    localparam int STEP_SEC_MAX = 15;
    localparam int NS_HI_W      = NS_W - HALF_W;
    localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;

    localparam logic [ADDR_W-1:0] A_SET_SEC_HI  = 4'd0;
    localparam logic [ADDR_W-1:0] A_SET_SEC_LO  = 4'd1;
    localparam logic [ADDR_W-1:0] A_SET_NS_HI   = 4'd2;
    localparam logic [ADDR_W-1:0] A_SET_NS_LO   = 4'd3;
    localparam logic [ADDR_W-1:0] A_RATE_HI     = 4'd4;
    localparam logic [ADDR_W-1:0] A_RATE_LO     = 4'd5;
    localparam logic [ADDR_W-1:0] A_STEP_HI     = 4'd6;
    localparam logic [ADDR_W-1:0] A_STEP_LO     = 4'd7;
    localparam logic [ADDR_W-1:0] A_SNAP_SEC_HI = 4'd8;
    localparam logic [ADDR_W-1:0] A_SNAP_SEC_LO = 4'd9;
    localparam logic [ADDR_W-1:0] A_SNAP_NS_HI  = 4'd10;
    localparam logic [ADDR_W-1:0] A_SNAP_NS_LO  = 4'd11;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_LOAD     = 3'd1,
        OP_SNAP     = 3'd2,
        OP_RATE     = 3'd3,
        OP_STEP_SEC = 3'd4,
        OP_STEP_NS  = 3'd5
    } op_e;
endpackage

// File: rtl/ptc_regs.sv
// Staging registers, snapshot registers and read mux.
// Assumes one write per cycle; reads are combinational.
module ptc_regs
    import ptc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [HALF_W-1:0] rd_data,
    input  logic              snap_take,
    input  logic [SEC_W-1:0]  live_sec,
    input  logic [NS_W-1:0]   live_ns,
    output logic [SEC_W-1:0]  set_sec,
    output logic [NS_W-1:0]   set_ns,
    output logic              rate_fast,
    output logic [NS_W-1:0]   rate_mag,
    output logic              step_up,
    output logic [NS_W-1:0]   step_mag,
    output logic [SEC_W-1:0]  snap_sec,
    output logic [NS_W-1:0]   snap_ns
);
    localparam int PAD_DIR = HALF_W - 1 - NS_HI_W;
    localparam int PAD_NS  = HALF_W - NS_HI_W;

    logic unused_wr_bits;
    assign unused_wr_bits = &{1'b0, wr_data[HALF_W-2:NS_HI_W]};

    // Staging register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_sec   <= '0;
            set_ns    <= '0;
            rate_fast <= 1'b0;
            rate_mag  <= '0;
            step_up   <= 1'b0;
            step_mag  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_SET_SEC_HI: set_sec[SEC_W-1:HALF_W] <= wr_data[SEC_W-HALF_W-1:0];
                A_SET_SEC_LO: set_sec[HALF_W-1:0]     <= wr_data;
                A_SET_NS_HI:  set_ns[NS_W-1:HALF_W]   <= wr_data[NS_HI_W-1:0];
                A_SET_NS_LO:  set_ns[HALF_W-1:0]      <= wr_data;
                A_RATE_HI: begin
                    rate_fast               <= wr_data[HALF_W-1];
                    rate_mag[NS_W-1:HALF_W] <= wr_data[NS_HI_W-1:0];
                end
                A_RATE_LO:    rate_mag[HALF_W-1:0]    <= wr_data;
                A_STEP_HI: begin
                    step_up                 <= wr_data[HALF_W-1];
                    step_mag[NS_W-1:HALF_W] <= wr_data[NS_HI_W-1:0];
                end
                A_STEP_LO:    step_mag[HALF_W-1:0]    <= wr_data;
                default: ;
            endcase
        end
    end

    // Snapshot capture of the live time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_sec <= '0;
            snap_ns  <= '0;
        end else if (snap_take) begin
            snap_sec <= live_sec;
            snap_ns  <= live_ns;
        end
    end

    // Read mux
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_SET_SEC_HI:  rd_data = set_sec[SEC_W-1:HALF_W];
            A_SET_SEC_LO:  rd_data = set_sec[HALF_W-1:0];
            A_SET_NS_HI:   rd_data = {{PAD_NS{1'b0}}, set_ns[NS_W-1:HALF_W]};
            A_SET_NS_LO:   rd_data = set_ns[HALF_W-1:0];
            A_RATE_HI:     rd_data = {rate_fast, {PAD_DIR{1'b0}}, rate_mag[NS_W-1:HALF_W]};
            A_RATE_LO:     rd_data = rate_mag[HALF_W-1:0];
            A_STEP_HI:     rd_data = {step_up, {PAD_DIR{1'b0}}, step_mag[NS_W-1:HALF_W]};
            A_STEP_LO:     rd_data = step_mag[HALF_W-1:0];
            A_SNAP_SEC_HI: rd_data = snap_sec[SEC_W-1:HALF_W];
            A_SNAP_SEC_LO: rd_data = snap_sec[HALF_W-1:0];
            A_SNAP_NS_HI:  rd_data = {{PAD_NS{1'b0}}, snap_ns[NS_W-1:HALF_W]};
            A_SNAP_NS_LO:  rd_data = snap_ns[HALF_W-1:0];
            default:       rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ptc_frac_acc.sv
// Fractional rate accumulator: holds the active trim and yields this
// cycle's nanosecond increment (nominal, +1 on overflow, -1 on underflow).
// Assumes the trim magnitude is below 2^30, so the increment is 3..5.
module ptc_frac_acc
    import ptc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rate_take,
    input  logic             rate_fast_in,
    input  logic [NS_W-1:0]  rate_mag_in,
    output logic [NS_W-1:0]  act_mag,
    output logic [INC_W-1:0] ns_inc
);
    logic              act_fast;
    logic [FRAC_W-1:0] frac_q;
    logic [FRAC_W:0]   sum;
    logic [FRAC_W:0]   diff;
    logic              carry;
    logic              borrow;

    // Carry and borrow out of the fraction for this cycle
    always_comb begin
        sum    = {1'b0, frac_q} + (FRAC_W+1)'(act_mag);
        diff   = {1'b0, frac_q} - (FRAC_W+1)'(act_mag);
        carry  = act_fast & sum[FRAC_W];
        borrow = ~act_fast & diff[FRAC_W];
        ns_inc = INC_W'(NOM_INC) + INC_W'(carry) - INC_W'(borrow);
    end

    // Active trim register and fraction update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_fast <= 1'b0;
            act_mag  <= '0;
            frac_q   <= '0;
        end else begin
            frac_q <= act_fast ? sum[FRAC_W-1:0] : diff[FRAC_W-1:0];
            if (rate_take) begin
                act_fast <= rate_fast_in;
                act_mag  <= rate_mag_in;
            end
        end
    end
endmodule

// File: rtl/ptc_time_core.sv
// Seconds/nanoseconds registers: tick, wrap, load and both steps.
// Assumes at most one command per cycle and loaded nanoseconds < 1e9.
module ptc_time_core
    import ptc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_load,
    input  logic             do_step_sec,
    input  logic             do_step_ns,
    input  logic [SEC_W-1:0] set_sec,
    input  logic [NS_W-1:0]  set_ns,
    input  logic             step_up,
    input  logic [NS_W-1:0]  step_mag,
    input  logic [INC_W-1:0] ns_inc,
    output logic [SEC_W-1:0] sec_q,
    output logic [NS_W-1:0]  ns_q
);
    localparam logic [31:0] TWO_SEC = NS_PER_SEC + NS_PER_SEC;

    logic [31:0]      ns_sum;
    logic [31:0]      ns_fold;
    logic [1:0]       sec_carry;
    logic [SEC_W-1:0] sec_mag;
    logic [SEC_W-1:0] sec_base;
    logic [SEC_W-1:0] sec_next;

    // Next-time arithmetic: tick plus optional offset, folded at 1e9
    always_comb begin
        ns_sum = 32'(ns_q) + 32'(ns_inc) + (do_step_ns ? 32'(step_mag) : 32'd0);
        if (ns_sum >= TWO_SEC) begin
            ns_fold   = ns_sum - TWO_SEC;
            sec_carry = 2'd2;
        end else if (ns_sum >= NS_PER_SEC) begin
            ns_fold   = ns_sum - NS_PER_SEC;
            sec_carry = 2'd1;
        end else begin
            ns_fold   = ns_sum;
            sec_carry = 2'd0;
        end
        sec_mag  = (step_mag > NS_W'(STEP_SEC_MAX)) ? SEC_W'(STEP_SEC_MAX) : SEC_W'(step_mag);
        sec_base = sec_q + SEC_W'(sec_carry);
        if (do_step_sec)
            sec_next = step_up ? sec_base + sec_mag : sec_base - sec_mag;
        else
            sec_next = sec_base;
    end

    // Time registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            ns_q  <= '0;
        end else if (do_load) begin
            sec_q <= set_sec;
            ns_q  <= set_ns;
        end else begin
            sec_q <= sec_next;
            ns_q  <= NS_W'(ns_fold);
        end
    end
endmodule

// File: rtl/ptp_time_counter.sv
// Top of the time-of-day counter: decodes the command strobe and ties the
// register block, rate accumulator and time core together.
module ptp_time_counter
    import ptc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [HALF_W-1:0] reg_wr_data,
    input  logic [ADDR_W-1:0] reg_rd_addr,
    output logic [HALF_W-1:0] reg_rd_data,
    input  logic              cmd_strobe,
    input  logic [2:0]        cmd_code,
    output logic [SEC_W-1:0]  tod_sec,
    output logic [NS_W-1:0]   tod_ns
);
    logic             do_load, do_snap, do_rate, do_ssec, do_sns;
    logic [SEC_W-1:0] set_sec, snap_sec;
    logic [NS_W-1:0]  set_ns, snap_ns, rate_mag, step_mag, act_mag;
    logic             rate_fast, step_up;
    logic [INC_W-1:0] ns_inc;

    // Command decode
    always_comb begin
        do_load = cmd_strobe && (cmd_code == OP_LOAD);
        do_snap = cmd_strobe && (cmd_code == OP_SNAP);
        do_rate = cmd_strobe && (cmd_code == OP_RATE);
        do_ssec = cmd_strobe && (cmd_code == OP_STEP_SEC);
        do_sns  = cmd_strobe && (cmd_code == OP_STEP_NS);
    end

    ptc_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
        .snap_take(do_snap), .live_sec(tod_sec), .live_ns(tod_ns),
        .set_sec(set_sec), .set_ns(set_ns),
        .rate_fast(rate_fast), .rate_mag(rate_mag),
        .step_up(step_up), .step_mag(step_mag),
        .snap_sec(snap_sec), .snap_ns(snap_ns)
    );

    ptc_frac_acc u_acc (
        .clk(clk), .rst_n(rst_n),
        .rate_take(do_rate), .rate_fast_in(rate_fast), .rate_mag_in(rate_mag),
        .act_mag(act_mag), .ns_inc(ns_inc)
    );

    ptc_time_core u_core (
        .clk(clk), .rst_n(rst_n),
        .do_load(do_load), .do_step_sec(do_ssec), .do_step_ns(do_sns),
        .set_sec(set_sec), .set_ns(set_ns),
        .step_up(step_up), .step_mag(step_mag), .ns_inc(ns_inc),
        .sec_q(tod_sec), .ns_q(tod_ns)
    );
endmodule

// File: rtl/ptp_time_counter_chk.sv
// Checker for the time-of-day counter, bound to the top module.
// Assumes legal loads (nanoseconds below one billion).
module ptp_time_counter_chk
    import ptc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_strobe,
    input logic [2:0]       cmd_code,
    input logic [SEC_W-1:0] tod_sec,
    input logic [NS_W-1:0]  tod_ns,
    input logic [SEC_W-1:0] set_sec,
    input logic [NS_W-1:0]  set_ns,
    input logic [SEC_W-1:0] snap_sec,
    input logic [NS_W-1:0]  snap_ns,
    input logic             step_up,
    input logic [NS_W-1:0]  act_mag
);
    // R3
    ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tod_ns) < NS_PER_SEC);

    // R2
    nominal_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_strobe && act_mag == '0 && 32'(tod_ns) < NS_PER_SEC - 32'd4)
        |=> (tod_ns == $past(tod_ns) + NS_W'(NOM_INC)) && $stable(tod_sec));

    // R4
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && cmd_code == OP_LOAD)
        |=> (tod_sec == $past(set_sec)) && (tod_ns == $past(set_ns)));

    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_strobe && cmd_code == OP_SNAP)
        |=> $stable(snap_sec) && $stable(snap_ns));

    // R7
    sec_step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && cmd_code == OP_STEP_SEC && step_up)
        |=> (tod_sec - $past(tod_sec)) <= 32'd16);
endmodule

bind ptp_time_counter ptp_time_counter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .set_sec(set_sec), .set_ns(set_ns),
    .snap_sec(snap_sec), .snap_ns(snap_ns), .step_up(step_up), .act_mag(act_mag)
);

// File: tb/ptp_time_counter_tb.sv
// Scoreboard bench: driver tasks queue expectations, a monitor compares them
// shortly after each falling edge.
module ptp_time_counter_tb;
    import ptc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_wr_addr = '0;
    logic [15:0] reg_wr_data = '0;
    logic [3:0]  reg_rd_addr = '0;
    logic [15:0] reg_rd_data;
    logic        cmd_strobe = 1'b0;
    logic [2:0]  cmd_code = '0;
    logic [31:0] tod_sec;
    logic [29:0] tod_ns;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    bit    q_kind[$];
    string q_tag[$];
    logic [31:0] q_sec[$];
    logic [31:0] q_val[$];

    always #2 clk = ~clk;

    ptp_time_counter u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
        .tod_sec(tod_sec), .tod_ns(tod_ns)
    );

    // Monitor: pop and compare queued expectations after each falling edge
    always begin
        @(negedge clk);
        #1;
        while (q_kind.size() > 0) begin
            bit k;
            string t;
            logic [31:0] es, ev;
            k  = q_kind.pop_front();
            t  = q_tag.pop_front();
            es = q_sec.pop_front();
            ev = q_val.pop_front();
            total++;
            if (k == 1'b0) begin
                if (tod_sec !== es || 32'(tod_ns) !== ev) begin
                    bad++;
                    $display("FAIL %s: actual sec=%0d ns=%0d expected sec=%0d ns=%0d",
                             t, tod_sec, tod_ns, es, ev);
                end
            end else begin
                if (32'(reg_rd_data) !== ev) begin
                    bad++;
                    $display("FAIL %s: actual rd=0x%04h expected rd=0x%04h",
                             t, reg_rd_data, ev[15:0]);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] c);
        cmd_strobe = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_strobe = 1'b0; cmd_code = '0;
    endtask

    task automatic exp_time(input string t, input logic [31:0] s, input logic [31:0] n);
        q_kind.push_back(1'b0); q_tag.push_back(t); q_sec.push_back(s); q_val.push_back(n);
    endtask

    task automatic exp_rd(input string t, input logic [3:0] a, input logic [15:0] v);
        reg_rd_addr = a;
        q_kind.push_back(1'b1); q_tag.push_back(t); q_sec.push_back('0); q_val.push_back(32'(v));
        idle(1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        summary();
    end

    // Driver
    initial begin
        // R1 reset state
        do_reset();
        exp_time("R1 time after reset", 0, 0);
        exp_rd("R1 snapshot seconds low", A_SNAP_SEC_LO, 16'h0000);
        exp_rd("R1 set seconds low", A_SET_SEC_LO, 16'h0000);

        // R2 nominal rate: 2 read cycles already elapsed, then 23 more
        idle(23);
        exp_time("R2 nominal 4 ns per cycle", 0, 100);

        // R4 load and R5 snapshot
        do_reset();
        wr(A_SET_SEC_HI, 16'h0001);
        wr(A_SET_SEC_LO, 16'h2345);
        wr(A_SET_NS_HI,  16'h0ABC);
        wr(A_SET_NS_LO,  16'hDEF0);
        cmd(OP_LOAD);
        exp_time("R4 load copies staged time", 32'h0001_2345, 32'h0ABC_DEF0);
        cmd(OP_SNAP);
        exp_time("R5 time runs after snapshot", 32'h0001_2345, 32'h0ABC_DEF4);
        idle(10);
        exp_rd("R5 snapshot seconds high", A_SNAP_SEC_HI, 16'h0001);
        exp_rd("R5 snapshot seconds low",  A_SNAP_SEC_LO, 16'h2345);
        exp_rd("R5 snapshot ns high",      A_SNAP_NS_HI,  16'h0ABC);
        exp_rd("R5 snapshot ns low",       A_SNAP_NS_LO,  16'hDEF0);
        wr(A_SET_NS_HI, 16'hFFFF);
        exp_rd("R4 ns high keeps 14 bits", A_SET_NS_HI, 16'h3FFF);

        // R3 wrap at one billion
        do_reset();
        wr(A_SET_SEC_LO, 16'd5);
        wr(A_SET_NS_HI, 16'h3B9A);
        wr(A_SET_NS_LO, 16'hC9FC);
        cmd(OP_LOAD);
        exp_time("R3 loaded just below wrap", 5, 999_999_996);
        idle(1);
        exp_time("R3 wrap carries a second", 6, 0);
        idle(1);
        exp_time("R3 counting after wrap", 6, 4);

        // R8 nanosecond step, direction ignored, with carries
        wr(A_STEP_HI, 16'h0000);
        wr(A_STEP_LO, 16'd100);
        cmd(OP_STEP_NS);
        exp_time("R8 step adds with tick", 6, 116);
        wr(A_STEP_LO, 16'd200);
        wr(A_SET_NS_HI, 16'h3B9A);
        wr(A_SET_NS_LO, 16'hC99C);
        cmd(OP_LOAD);
        cmd(OP_STEP_NS);
        exp_time("R8 step carries one second", 6, 104);
        wr(A_STEP_HI, 16'hBFFF);
        wr(A_STEP_LO, 16'hFFFF);
        cmd(OP_LOAD);
        cmd(OP_STEP_NS);
        exp_time("R8 step carries two seconds", 7, 73_741_727);

        // R7 seconds step up, down and clamped
        do_reset();
        wr(A_SET_SEC_LO, 16'd100);
        cmd(OP_LOAD);
        exp_time("R7 base load", 100, 0);
        wr(A_STEP_HI, 16'h8000);
        wr(A_STEP_LO, 16'd7);
        cmd(OP_STEP_SEC);
        exp_time("R7 step up by 7", 107, 12);
        wr(A_STEP_HI, 16'h0000);
        cmd(OP_STEP_SEC);
        exp_time("R7 step down by 7", 100, 20);
        wr(A_STEP_LO, 16'd100);
        wr(A_STEP_HI, 16'h8000);
        cmd(OP_STEP_SEC);
        exp_time("R7 step clamped to 15", 115, 32);
        wr(A_STEP_HI, 16'h8001);
        cmd(OP_STEP_SEC);
        exp_time("R7 large magnitude clamped to 15", 130, 40);

        // R10 staged rate has no effect before the rate command; R6 faster
        do_reset();
        wr(A_RATE_HI, 16'h9000);
        wr(A_RATE_LO, 16'h0000);
        idle(160);
        exp_time("R10 staged rate inactive", 0, 648);
        cmd(OP_RATE);
        cmd(OP_LOAD);
        idle(160);
        exp_time("R6 faster trim adds 10 ns", 0, 650);

        // R6 slower
        do_reset();
        wr(A_RATE_HI, 16'h1000);
        wr(A_RATE_LO, 16'h0000);
        cmd(OP_RATE);
        cmd(OP_LOAD);
        idle(160);
        exp_time("R6 slower trim removes 10 ns", 0, 630);

        // R9 unused codes and unstrobed codes
        do_reset();
        wr(A_SET_SEC_LO, 16'd9);
        cmd(3'd0);
        cmd(3'd6);
        cmd(3'd7);
        cmd_strobe = 1'b0; cmd_code = OP_LOAD;
        @(negedge clk);
        cmd_code = '0;
        exp_time("R9 ignored codes leave nominal count", 0, 20);

        idle(2);
        summary();
    end
endmodule